// File: doc/BRIEF.md
# Configurable I/O Logic Macrocell

This block is one programmable cell placed between a group of sum-of-products terms and a bidirectional pin. The OR-gate result arrives as an input. Nine static configuration bits select the cell's behaviour:

- a combinatorial path or a stored path;
- the output polarity;
- edge-triggered or level-sensitive storage;
- whether the storage element captures array data (output cell) or pin data (input cell);
- which strobe source and which polarity clocks or opens the storage;
- how the pin driver is enabled;
- for the single-feedback variant, which value returns to the array.

The pin is modelled as three separate signals: a driven value, a drive enable and the sampled pin level.

Everything in the cell runs on one system clock. The pin clock and the product-term clock are ordinary data inputs, and the cell samples them on that clock. A register captures at the system edge where the selected source is first seen to have made the chosen transition. A latch reloads on every system edge while its enable level is active. The set and clear product terms act on the next system edge, whatever the strobe is doing. Two test controls complete the cell. Preload writes the pin value into the storage on a strobe. Observe puts the stored bit on the pin.

Configuration bit `cfg_bits[i]` is called S_i below. An unprogrammed (erased) bit is 1.

Top module: `iomc_cell`

## Requirements
- R1: With S1=1 and S3=1, or with S3=0 (input cell), and observe low, `pin_out` equals `and_or_sum` XOR S0, with no clock delay.
- R2: With S1=0 and S3=1 and observe low, `pin_out` equals the stored bit XOR S0 (S0=1 is active-low).
- R3: With S2=1 the storage is a register. S4=1 selects `pin_clk` and S4=0 selects `pt_clk`. S5=1 captures on a rising transition and S5=0 on a falling one. The stored bit changes at the system clock edge where the new source level is first sampled, and transitions of the other kind, or on the unselected source, leave it unchanged.
- R4: With S2=0 the storage is a latch. It reloads on every system edge while the selected source is low (S5=1) or high (S5=0), and holds while the source is at the other level.
- R5: With S3=0 the storage captures `pin_in` instead of `and_or_sum`. The stored bit then reaches only the feedback path, and `pin_out` stays on the combinatorial sum.
- R6: The drive enable is selected by {S6,S7}: 11 follows `oe_pin`, 10 follows `oe_term`, 01 is always on and 00 is always off.
- R7: In the single-feedback variant, `fb_main` is the stored bit when S8=1 and `pin_in` when S8=0, and `fb_aux` is 0. In the dual-feedback variant, `fb_main` is always `pin_in` and `fb_aux` is always the stored bit.
- R8: `ap_clr` forces the stored bit to 0 and `ap_set` forces it to 1 at the next system edge, regardless of the strobe. `ap_clr` wins when both are high.
- R9: While `rst` is high, the stored bit is cleared and `cfg_bits` is copied into the cell. While `rst` is low, changes on `cfg_bits` have no effect.
- R10: While `observe` is high, `pin_oe` is 1 and `pin_out` is the stored bit XOR S0, whatever {S6,S7} and S1 select.
- R11: While `preload` is high, a storage strobe loads `pin_in` in place of `and_or_sum`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; configuration load window |
| cfg_bits | input | 9 | Configuration bits, bit i = S_i |
| and_or_sum | input | 1 | OR of the cell's product terms |
| pin_in | input | 1 | Sampled pin level |
| pin_clk | input | 1 | Common clock / enable pin level |
| pt_clk | input | 1 | Clock / enable product term level |
| oe_pin | input | 1 | Common output-enable pin |
| oe_term | input | 1 | Output-enable product term |
| ap_set | input | 1 | Preset product term |
| ap_clr | input | 1 | Clear product term |
| preload | input | 1 | Preload test control |
| observe | input | 1 | Observe test control |
| pin_out | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Pin drive enable |
| fb_main | output | 1 | Primary feedback to the array |
| fb_aux | output | 1 | Stored-bit feedback (dual variant), else 0 |

## Verification
The assertions assume that `cfg_bits` is meaningful only during reset. They also assume that set, clear and observe are sampled on the system clock like every other input. The bench therefore changes the configuration only inside a reset pulse, which at the same time clears the stored bit to a known 0. It moves every input at the falling system edge, so that each strobe transition is seen at exactly one rising edge.

// File: rtl/iomc_pkg.sv
`timescale 1ns/1ps
package iomc_pkg;

    localparam int CFG_W = 9;

    // Drive-enable selection, encoded as {S6,S7}
    typedef enum logic [1:0] {
        DRV_OFF  = 2'b00,
        DRV_ON   = 2'b01,
        DRV_TERM = 2'b10,
        DRV_PIN  = 2'b11
    } drive_mode_e;

    typedef struct packed {
        logic        fb_store;   // S8
        drive_mode_e drive;      // {S6,S7}
        logic        edge_rise;  // S5: rising edge / low-level enable
        logic        strobe_pin; // S4: pin source when 1
        logic        out_side;   // S3: array data when 1
        logic        use_ff;     // S2: register when 1, latch when 0
        logic        bypass;     // S1: combinatorial when 1
        logic        invert;     // S0: active-low when 1
    } cell_cfg_t;

    function automatic cell_cfg_t decode_cfg(input logic [CFG_W-1:0] b);
        cell_cfg_t c;
        c.invert     = b[0];
        c.bypass     = b[1];
        c.use_ff     = b[2];
        c.out_side   = b[3];
        c.strobe_pin = b[4];
        c.edge_rise  = b[5];
        c.drive      = drive_mode_e'({b[6], b[7]});
        c.fb_store   = b[8];
        return c;
    endfunction

endpackage

// File: rtl/iomc_strobe.sv
`timescale 1ns/1ps
module iomc_strobe (
    input  logic clk,
    input  logic rst,
    input  logic strobe_pin,
    input  logic edge_rise,
    input  logic use_ff,
    input  logic pin_clk,
    input  logic pt_clk,
    output logic capture
);
    logic prev_pin, prev_pt;
    logic src, prev;

    always_ff @(posedge clk) begin
        prev_pin <= pin_clk;
        prev_pt  <= pt_clk;
    end

    always_comb begin
        src = strobe_pin ? pin_clk : pt_clk;
        prev = strobe_pin ? prev_pin : prev_pt;
        if (rst)
            capture = 1'b0;
        else if (use_ff)
            capture = edge_rise ? (src & ~prev) : (~src & prev);
        else
            capture = edge_rise ? ~src : src;
    end
endmodule

// File: rtl/iomc_store.sv
`timescale 1ns/1ps
module iomc_store (
    input  logic clk,
    input  logic rst,
    input  logic capture,
    input  logic d,
    input  logic ap_set,
    input  logic ap_clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (ap_clr)
            q <= 1'b0;
        else if (ap_set)
            q <= 1'b1;
        else if (capture)
            q <= d;
    end
endmodule

// File: rtl/iomc_drive.sv
`timescale 1ns/1ps
module iomc_drive
    import iomc_pkg::*;
#(
    parameter bit DUAL_FB = 1'b0
) (
    input  logic        invert,
    input  logic        bypass,
    input  logic        out_side,
    input  drive_mode_e drive,
    input  logic        fb_store,
    input  logic        sum,
    input  logic        q,
    input  logic        pin_in,
    input  logic        oe_pin,
    input  logic        oe_term,
    input  logic        observe,
    output logic        pin_out,
    output logic        pin_oe,
    output logic        fb_main,
    output logic        fb_aux
);
    logic pre_pol;

    always_comb begin
        if (observe)
            pre_pol = q;
        else if (bypass || !out_side)
            pre_pol = sum;
        else
            pre_pol = q;
        pin_out = pre_pol ^ invert;

        unique case (drive)
            DRV_PIN:  pin_oe = oe_pin;
            DRV_TERM: pin_oe = oe_term;
            DRV_ON:   pin_oe = 1'b1;
            default:  pin_oe = 1'b0;
        endcase
        if (observe)
            pin_oe = 1'b1;
    end

    generate
        if (DUAL_FB) begin : g_dual
            assign fb_main = pin_in;
            assign fb_aux  = q;
        end else begin : g_single
            assign fb_main = fb_store ? q : pin_in;
            assign fb_aux  = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/iomc_cell.sv
`timescale 1ns/1ps
module iomc_cell
    import iomc_pkg::*;
#(
    parameter bit DUAL_FB = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_bits,
    input  logic             and_or_sum,
    input  logic             pin_in,
    input  logic             pin_clk,
    input  logic             pt_clk,
    input  logic             oe_pin,
    input  logic             oe_term,
    input  logic             ap_set,
    input  logic             ap_clr,
    input  logic             preload,
    input  logic             observe,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             fb_main,
    output logic             fb_aux
);
    logic [CFG_W-1:0] cfg_q;
    cell_cfg_t        cfg;
    logic             capture;
    logic             store_d;
    logic             store_q;

    // Configuration is copied only during reset
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= cfg_bits;
    end

    assign cfg     = decode_cfg(cfg_q);
    assign store_d = (preload || !cfg.out_side) ? pin_in : and_or_sum;

    iomc_strobe u_strobe (
        .clk        (clk),
        .rst        (rst),
        .strobe_pin (cfg.strobe_pin),
        .edge_rise  (cfg.edge_rise),
        .use_ff     (cfg.use_ff),
        .pin_clk    (pin_clk),
        .pt_clk     (pt_clk),
        .capture    (capture)
    );

    iomc_store u_store (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .d       (store_d),
        .ap_set  (ap_set),
        .ap_clr  (ap_clr),
        .q       (store_q)
    );

    iomc_drive #(.DUAL_FB(DUAL_FB)) u_drive (
        .invert   (cfg.invert),
        .bypass   (cfg.bypass),
        .out_side (cfg.out_side),
        .drive    (cfg.drive),
        .fb_store (cfg.fb_store),
        .sum      (and_or_sum),
        .q        (store_q),
        .pin_in   (pin_in),
        .oe_pin   (oe_pin),
        .oe_term  (oe_term),
        .observe  (observe),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .fb_main  (fb_main),
        .fb_aux   (fb_aux)
    );
endmodule

// File: rtl/iomc_cell_chk.sv
`timescale 1ns/1ps
module iomc_cell_chk (
    input logic       clk,
    input logic       rst,
    input logic [8:0] cfg_q,
    input logic       store_q,
    input logic       and_or_sum,
    input logic       ap_set,
    input logic       ap_clr,
    input logic       observe,
    input logic       pin_out,
    input logic       pin_oe
);
    assert_clr_wins_R8: assert property (@(posedge clk) disable iff (rst)
        ap_clr |=> (store_q == 1'b0));

    assert_set_forces_R8: assert property (@(posedge clk) disable iff (rst)
        (ap_set && !ap_clr) |=> (store_q == 1'b1));

    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(cfg_q));

    assert_observe_drives_R10: assert property (@(posedge clk) disable iff (rst)
        observe |-> (pin_oe && (pin_out == (store_q ^ cfg_q[0]))));

    assert_never_driven_R6: assert property (@(posedge clk) disable iff (rst)
        (!observe && cfg_q[6] == 1'b0 && cfg_q[7] == 1'b0) |-> !pin_oe);

    assert_comb_path_R1: assert property (@(posedge clk) disable iff (rst)
        (!observe && cfg_q[1] && cfg_q[3]) |-> (pin_out == (and_or_sum ^ cfg_q[0])));
endmodule

bind iomc_cell iomc_cell_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_q      (cfg_q),
    .store_q    (store_q),
    .and_or_sum (and_or_sum),
    .ap_set     (ap_set),
    .ap_clr     (ap_clr),
    .observe    (observe),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe)
);

// File: tb/iomc_cell_test.sv
`timescale 1ns/1ps
module iomc_cell_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] cfg_bits = '1;
    logic       sum = 0, pin_in = 0, pin_clk = 0, pt_clk = 0;
    logic       oe_pin = 0, oe_term = 0, ap_set = 0, ap_clr = 0;
    logic       preload = 0, observe = 0;
    logic       pin_out, pin_oe, fb_main, fb_aux;
    logic       d_out, d_oe, d_fbm, d_fba;
    int         runs = 0, fails = 0;

    always #2.5 clk = ~clk;

    iomc_cell uut (
        .clk(clk), .rst(rst), .cfg_bits(cfg_bits), .and_or_sum(sum),
        .pin_in(pin_in), .pin_clk(pin_clk), .pt_clk(pt_clk),
        .oe_pin(oe_pin), .oe_term(oe_term), .ap_set(ap_set), .ap_clr(ap_clr),
        .preload(preload), .observe(observe),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb_main(fb_main), .fb_aux(fb_aux)
    );

    iomc_cell #(.DUAL_FB(1'b1)) uut_dual (
        .clk(clk), .rst(rst), .cfg_bits(cfg_bits), .and_or_sum(sum),
        .pin_in(pin_in), .pin_clk(pin_clk), .pt_clk(pt_clk),
        .oe_pin(oe_pin), .oe_term(oe_term), .ap_set(ap_set), .ap_clr(ap_clr),
        .preload(preload), .observe(observe),
        .pin_out(d_out), .pin_oe(d_oe), .fb_main(d_fbm), .fb_aux(d_fba)
    );

    // {cfg S8..S0, sum, pin_in, oe_pin, oe_term, observe, exp_out, exp_oe, exp_fb}
    localparam int NV = 13;
    localparam logic [16:0] VECS [NV] = '{
        {9'b110111110, 5'b10000, 3'b110},  // R1 comb high
        {9'b110111110, 5'b00000, 3'b010},  // R1
        {9'b110111111, 5'b10000, 3'b010},  // R1 comb low
        {9'b110111111, 5'b00000, 3'b110},  // R1
        {9'b110111100, 5'b10000, 3'b010},  // R2 stored high
        {9'b110111101, 5'b00000, 3'b110},  // R2 stored low
        {9'b111111110, 5'b10000, 3'b100},  // R6 pin enable off
        {9'b111111110, 5'b10100, 3'b110},  // R6 pin enable on
        {9'b101111110, 5'b10010, 3'b110},  // R6 term enable on
        {9'b101111110, 5'b10100, 3'b100},  // R6 term enable off
        {9'b100111110, 5'b10110, 3'b100},  // R6 never driven
        {9'b100111110, 5'b10001, 3'b010},  // R10 observe
        {9'b010111110, 5'b01000, 3'b011}   // R7 pin feedback
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        runs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic apply_cfg(input logic [8:0] c);
        cfg_bits = c; rst = 1'b1;
        sum = 0; pin_in = 0; pin_clk = 0; pt_clk = 0;
        oe_pin = 0; oe_term = 0; ap_set = 0; ap_clr = 0;
        preload = 0; observe = 0;
        tick(); tick();
        rst = 1'b0;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            apply_cfg(VECS[i][16:8]);
            {sum, pin_in, oe_pin, oe_term, observe} = VECS[i][7:3];
            tick();
            check($sformatf("vec%0d out R1/R2/R10", i), pin_out, VECS[i][2]);
            check($sformatf("vec%0d oe R6", i), pin_oe, VECS[i][1]);
            check($sformatf("vec%0d fb R7", i), fb_main, VECS[i][0]);
        end

        // R9 reset state, R3 pin rising register
        apply_cfg(9'b110111100);
        check("R9 reset clears", pin_out, 1'b0);
        sum = 1; tick();
        check("R3 no edge holds", pin_out, 1'b0);
        pin_clk = 1; tick();
        check("R3 rising captures", pin_out, 1'b1);
        sum = 0; pin_clk = 0; tick();
        check("R3 falling ignored", pin_out, 1'b1);
        pin_clk = 1; tick();
        check("R3 second rise", pin_out, 1'b0);

        // R3 product-term falling register
        apply_cfg(9'b110001100);
        sum = 1; pt_clk = 1; tick();
        check("R3 pt rise ignored", pin_out, 1'b0);
        pt_clk = 0; tick();
        check("R3 pt fall captures", pin_out, 1'b1);
        sum = 0; pin_clk = 1; tick(); pin_clk = 0; tick();
        check("R3 unselected source", pin_out, 1'b1);

        // R4 latch, pin source, active-high enable
        apply_cfg(9'b110011000);
        sum = 1; tick();
        check("R4 closed holds", pin_out, 1'b0);
        pin_clk = 1; tick();
        check("R4 opens", pin_out, 1'b1);
        sum = 0; tick();
        check("R4 transparent follows", pin_out, 1'b0);
        pin_clk = 0; sum = 1; tick(); tick();
        check("R4 closes", pin_out, 1'b0);

        // R4 latch, product-term source, active-low enable
        apply_cfg(9'b110101000);
        sum = 1; tick();
        check("R4 low enable open", pin_out, 1'b1);
        pt_clk = 1; sum = 0; tick();
        check("R4 low enable hold", pin_out, 1'b1);

        // R8 set / clear priority
        apply_cfg(9'b110111100);
        ap_set = 1; tick();
        check("R8 set", pin_out, 1'b1);
        ap_set = 0; ap_clr = 1; tick();
        check("R8 clear", pin_out, 1'b0);
        ap_set = 1; tick();
        check("R8 clear wins", pin_out, 1'b0);
        ap_clr = 0; tick();
        check("R8 set after clear", pin_out, 1'b1);

        // R11 preload
        apply_cfg(9'b110111100);
        pin_in = 1; preload = 1; pin_clk = 1; tick();
        check("R11 preload loads pin", pin_out, 1'b1);
        preload = 0; pin_clk = 0; tick(); pin_clk = 1; tick();
        check("R11 normal after preload", pin_out, 1'b0);

        // R5 input cell, R7 dual variant
        apply_cfg(9'b110110100);
        sum = 1; pin_in = 1; tick();
        check("R5 out is sum", pin_out, 1'b1);
        check("R5 fb before strobe", fb_main, 1'b0);
        pin_clk = 1; tick();
        check("R5 fb holds pin", fb_main, 1'b1);
        sum = 0; tick();
        check("R5 out still sum", pin_out, 1'b0);
        pin_in = 0; tick();
        check("R7 dual fb_main pin", d_fbm, 1'b0);
        check("R7 dual fb_aux stored", d_fba, 1'b1);
        check("R7 single fb_aux zero", fb_aux, 1'b0);

        // R9 configuration ignored outside reset
        apply_cfg(9'b110111100);
        cfg_bits = 9'b000000011; sum = 1; tick();
        check("R9 cfg ignored oe", pin_oe, 1'b1);
        check("R9 cfg ignored out", pin_out, 1'b0);

        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule